// File: doc/BRIEF.md
# SPI EEPROM Boot Loader

This block starts by itself when reset is released. It acts as an SPI master and copies a code image from a serial EEPROM into on-chip memory. Every transfer uses clock mode 0 with 8-bit frames, most significant bit first, and a single active-low chip select. The block makes two read passes over the EEPROM. Each pass begins with the read command 0x03 followed by a start address of zero.

The first pass clocks six bytes. It looks for the marker 0x5A in two places. Where the marker appears tells the block whether the EEPROM takes one address byte or two. The byte after the marker is a size index, and the image length is that index times 16 bytes. The second pass reads from address zero again and skips the command, address, marker and size bytes. It then pairs the image bytes into halfwords and writes them out through a simple write strobe, starting at a base address. When the last halfword has been written, a one-cycle done pulse is raised.

A bad header is signalled on chip select itself. A missing marker gives two extra low pulses and a zero size index gives three. After the pulses the block halts with a status output held high.

Top module: `spi_boot_loader`

## Requirements
- R1: SCLK is low whenever chip select is deasserted (high). While SCLK stays high, MOSI does not change. Bits travel most significant first, and MISO is sampled on the rising SCLK edge.
- R2: In each read pass the first byte sent on MOSI is 0x03 and every later byte of that pass is 0x00.
- R3: Each SCLK high phase lasts exactly CLK_HZ/(2*SPI_HZ) clock cycles, which is the reload value plus one, with reload = floor(CLK_HZ/(2*SPI_HZ)) - 1.
- R4: If byte 2 of the first pass (counting from 0) is 0x5A, the device takes one address byte. Byte 3 is then the size index, and the second pass clocks 4 + 16*size bytes.
- R5: If byte 2 is not 0x5A but byte 3 is, the device takes two address bytes. Byte 4 is then the size index, and the second pass clocks 5 + 16*size bytes.
- R6: If neither byte 2 nor byte 3 is 0x5A, chip select makes exactly two further low pulses after the first pass. The block then sets halted, makes no memory writes and raises no done pulse.
- R7: If the marker is found but the size index is 0, chip select makes exactly three further low pulses. The block then halts as in R6.
- R8: The image bytes of the second pass are taken in pairs. Each pair is written as wdata = {odd byte, even byte} at addresses BASE_ADDR, BASE_ADDR+2 and so on, 8*size writes in all. Write strobes are never asserted in back-to-back cycles.
- R9: Chip select is high during reset. Every high interval between two low intervals lasts at least 2*CLK_HZ/(2*SPI_HZ) clock cycles. Chip select stays high after the final byte.
- R10: After the last write, load_done pulses for exactly one cycle with load_addr equal to BASE_ADDR. Once halted is set it stays set, and chip select stays high.
- R11: The first pass clocks exactly 6 bytes, which is 48 rising SCLK edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; the load starts when it is released |
| spi_miso | input | 1 | Serial data from the EEPROM |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_cs_n | output | 1 | Active-low chip select |
| mem_we | output | 1 | Halfword write strobe |
| mem_addr | output | ADDR_W | Halfword write address |
| mem_wdata | output | 16 | Halfword write data, odd byte in the upper half |
| load_done | output | 1 | One-cycle pulse when the image is fully stored |
| load_addr | output | ADDR_W | Base address of the image, valid with load_done |
| halted | output | 1 | Held high after a header error |

## Verification
Some properties are checked by the assertions on every cycle:
- SCLK stays low while chip select is high.
- MOSI holds still during each SCLK high phase.
- Write strobes are spaced apart and occur only just after a read pass.
- The done pulse lasts one cycle.
- The halted state, with chip select high, is never left.

Other behaviour can only be shown by the bench scenarios. These cover:
- telling one-byte from two-byte addressing;
- the exact number of error pulses on chip select;
- the byte count of each pass;
- the command and zero-address bytes;
- the halfword contents and addresses compared against an EEPROM model;
- the width of the SCLK high phases and of the chip-select gaps.

// File: rtl/sbl_pkg.sv
package sbl_pkg;

    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] ID_MARK   = 8'h5A;
    localparam int unsigned SIZE_W   = 8;
    localparam int unsigned SIZE_SHIFT = 4;
    localparam int unsigned HDR_BYTES  = 6;
    localparam int unsigned SKIP_NARROW = 4;
    localparam int unsigned SKIP_WIDE   = 5;
    localparam int unsigned CNT_W = SIZE_W + SIZE_SHIFT + 1;
    localparam int unsigned GAP_TICKS = 3;
    localparam logic [1:0] PULSES_NO_ID   = 2'd2;
    localparam logic [1:0] PULSES_NO_SIZE = 2'd3;

    typedef enum logic [2:0] {
        ST_START,
        ST_ACC1,
        ST_GAP,
        ST_ACC2,
        ST_PULSE,
        ST_DONE,
        ST_IDLE,
        ST_HALT
    } sbl_state_e;

    typedef struct packed {
        logic              id_ok;
        logic              wide;
        logic [SIZE_W-1:0] size;
    } sbl_hdr_t;

    function automatic sbl_hdr_t decode_hdr(input logic [7:0] b2,
                                            input logic [7:0] b3,
                                            input logic [7:0] b4);
        sbl_hdr_t h;
        h.wide  = (b2 != ID_MARK);
        h.id_ok = (b2 == ID_MARK) || (b3 == ID_MARK);
        h.size  = h.wide ? b4 : b3;
        return h;
    endfunction

endpackage

// File: rtl/sbl_clkgen.sv
module sbl_clkgen #(
    parameter int unsigned RELOAD = 7
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = (RELOAD > 0) ? $clog2(RELOAD + 1) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(RELOAD)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/sbl_shifter.sv
module sbl_shifter (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       busy,
    output logic       rx_done,
    output logic [7:0] rx_byte
);
    logic [7:0] sh_tx;
    logic [7:0] sh_rx;
    logic [3:0] edges;

    assign mosi    = sh_tx[7];
    assign rx_byte = sh_rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_tx   <= '0;
            sh_rx   <= '0;
            edges   <= '0;
            sclk    <= 1'b0;
            busy    <= 1'b0;
            rx_done <= 1'b0;
        end else begin
            rx_done <= 1'b0;
            if (!busy) begin
                if (go) begin
                    sh_tx <= tx_byte;
                    edges <= '0;
                    busy  <= 1'b1;
                    sclk  <= 1'b0;
                end
            end else if (tick) begin
                if (!sclk) begin
                    sclk  <= 1'b1;
                    sh_rx <= {sh_rx[6:0], miso};
                    edges <= edges + 1'b1;
                end else begin
                    sclk <= 1'b0;
                    if (edges == 4'd8) begin
                        busy    <= 1'b0;
                        rx_done <= 1'b1;
                    end else begin
                        sh_tx <= {sh_tx[6:0], 1'b0};
                    end
                end
            end
        end
    end

    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi)); // R1

endmodule

// File: rtl/sbl_ctrl.sv
module sbl_ctrl
    import sbl_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hC000_0004
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              busy,
    input  logic              rx_done,
    input  logic [7:0]        rx_byte,
    output logic              go,
    output logic [7:0]        tx_byte,
    output logic              cs_n,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    output logic              load_done,
    output logic              halted
);
    localparam logic [1:0] GAP_LAST = 2'(GAP_TICKS - 1);

    sbl_state_e       st;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] total;
    logic [CNT_W-1:0] skip_q;
    logic [7:0]       hb2, hb3, hb4;
    logic [1:0]       gap_cnt;
    logic             pl_low;
    logic [1:0]       pl_left;
    logic [7:0]       lo_q;

    sbl_hdr_t         hdr;
    logic [CNT_W-1:0] skip_d;
    logic [CNT_W-1:0] total_d;
    logic [CNT_W-1:0] k;

    always_comb begin
        hdr     = decode_hdr(hb2, hb3, hb4);
        skip_d  = hdr.wide ? CNT_W'(SKIP_WIDE) : CNT_W'(SKIP_NARROW);
        total_d = skip_d + CNT_W'({hdr.size, {SIZE_SHIFT{1'b0}}});
        k       = idx - skip_q;
    end

    assign go      = ((st == ST_ACC1) || (st == ST_ACC2)) && !busy && !rx_done;
    assign tx_byte = (idx == '0) ? CMD_READ : 8'h00;
    assign cs_n    = !((st == ST_ACC1) || (st == ST_ACC2) || ((st == ST_PULSE) && pl_low));
    assign halted  = (st == ST_HALT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_START;
            idx       <= '0;
            total     <= '0;
            skip_q    <= '0;
            hb2       <= '0;
            hb3       <= '0;
            hb4       <= '0;
            gap_cnt   <= '0;
            pl_low    <= 1'b0;
            pl_left   <= '0;
            lo_q      <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            load_done <= 1'b0;
        end else begin
            mem_we    <= 1'b0;
            load_done <= 1'b0;
            case (st)
                ST_START: begin
                    st  <= ST_ACC1;
                    idx <= '0;
                end
                ST_ACC1: if (rx_done) begin
                    if (idx == CNT_W'(2)) hb2 <= rx_byte;
                    if (idx == CNT_W'(3)) hb3 <= rx_byte;
                    if (idx == CNT_W'(4)) hb4 <= rx_byte;
                    if (idx == CNT_W'(HDR_BYTES - 1)) begin
                        st      <= ST_GAP;
                        idx     <= '0;
                        gap_cnt <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_GAP: if (tick) begin
                    if (gap_cnt == GAP_LAST) begin
                        gap_cnt <= '0;
                        if (!hdr.id_ok) begin
                            st      <= ST_PULSE;
                            pl_low  <= 1'b1;
                            pl_left <= PULSES_NO_ID;
                        end else if (hdr.size == '0) begin
                            st      <= ST_PULSE;
                            pl_low  <= 1'b1;
                            pl_left <= PULSES_NO_SIZE;
                        end else begin
                            st     <= ST_ACC2;
                            skip_q <= skip_d;
                            total  <= total_d;
                        end
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                ST_ACC2: if (rx_done) begin
                    if (idx >= skip_q) begin
                        if (!k[0]) begin
                            lo_q <= rx_byte;
                        end else begin
                            mem_we    <= 1'b1;
                            mem_wdata <= {rx_byte, lo_q};
                            mem_addr  <= BASE_ADDR + ADDR_W'({k[CNT_W-1:1], 1'b0});
                        end
                    end
                    if (idx == total - CNT_W'(1)) st <= ST_DONE;
                    else                          idx <= idx + 1'b1;
                end
                ST_PULSE: if (tick) begin
                    if (gap_cnt == GAP_LAST) begin
                        gap_cnt <= '0;
                        if (pl_low) begin
                            pl_low <= 1'b0;
                        end else if (pl_left == 2'd1) begin
                            st <= ST_HALT;
                        end else begin
                            pl_left <= pl_left - 1'b1;
                            pl_low  <= 1'b1;
                        end
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                ST_DONE: begin
                    load_done <= 1'b1;
                    st        <= ST_IDLE;
                end
                default: ;
            endcase
        end
    end

    AST_WE_SPACED: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we); // R8
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && cs_n)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        load_done |=> (!load_done && !halted)); // R10

endmodule

// File: rtl/spi_boot_loader.sv
module spi_boot_loader
    import sbl_pkg::*;
#(
    parameter int unsigned CLK_HZ = 16_000_000,
    parameter int unsigned SPI_HZ = 1_000_000,
    parameter int unsigned ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hC000_0004
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_miso,
    output logic              spi_sclk,
    output logic              spi_mosi,
    output logic              spi_cs_n,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    output logic              load_done,
    output logic [ADDR_W-1:0] load_addr,
    output logic              halted
);
    localparam int unsigned RELOAD = CLK_HZ / (2 * SPI_HZ) - 1;

    logic       tick;
    logic       go;
    logic       busy;
    logic       rx_done;
    logic [7:0] tx_byte;
    logic [7:0] rx_byte;

    sbl_clkgen #(.RELOAD(RELOAD)) u_clk (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    sbl_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .go      (go),
        .tx_byte (tx_byte),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .busy    (busy),
        .rx_done (rx_done),
        .rx_byte (rx_byte)
    );

    sbl_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .busy      (busy),
        .rx_done   (rx_done),
        .rx_byte   (rx_byte),
        .go        (go),
        .tx_byte   (tx_byte),
        .cs_n      (spi_cs_n),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .load_done (load_done),
        .halted    (halted)
    );

    assign load_addr = load_done ? BASE_ADDR : '0;

    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk); // R1
    AST_WE_IN_READ: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(!spi_cs_n)); // R8

endmodule

// File: tb/spi_boot_loader_tb.sv
`timescale 1ns/1ps
module spi_boot_loader_tb;

    localparam int unsigned TB_CLK_HZ = 8;
    localparam int unsigned TB_SPI_HZ = 1;
    localparam int HALF = TB_CLK_HZ / (2 * TB_SPI_HZ);
    localparam logic [31:0] TB_BASE = 32'hC000_0004;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        miso = 1'b0;
    logic        spi_sclk, spi_mosi, spi_cs_n;
    logic        mem_we, load_done, halted;
    logic [31:0] mem_addr, load_addr;
    logic [15:0] mem_wdata;

    always #10 clk = ~clk;

    spi_boot_loader #(.CLK_HZ(TB_CLK_HZ), .SPI_HZ(TB_SPI_HZ), .ADDR_W(32), .BASE_ADDR(TB_BASE)) u_dut (
        .clk(clk), .rst(rst), .spi_miso(miso), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .load_done(load_done), .load_addr(load_addr), .halted(halted)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // EEPROM model
    bit         dev_wide;
    logic [7:0] ee_mem [64];
    int         ee_bits, win, bad_mosi, cs_falls, abits, pbit;
    int         rises [8];
    logic [7:0] mosi_sh;

    always @(negedge spi_cs_n) if (!rst) begin
        ee_bits = 0;
        miso = 1'b0;
        if (win < 8) win++;
        cs_falls++;
    end

    always @(posedge spi_sclk) if (!spi_cs_n) begin
        mosi_sh = {mosi_sh[6:0], spi_mosi};
        ee_bits++;
        if (win > 0) rises[win-1]++;
        if (ee_bits % 8 == 0)
            if (mosi_sh != ((ee_bits == 8) ? 8'h03 : 8'h00)) bad_mosi++;
    end

    always @(negedge spi_sclk) if (!spi_cs_n) begin
        abits = dev_wide ? 16 : 8;
        if (ee_bits >= 8 + abits) begin
            pbit = ee_bits - 8 - abits;
            miso = ee_mem[(pbit / 8) % 64][7 - (pbit % 8)];
        end else begin
            miso = 1'b0;
        end
    end

    // per-clock reference comparison
    logic [31:0] exp_addr [$];
    logic [15:0] exp_data [$];
    int hi_run, bad_high, bad_idle, cs_hi_run, min_gap, done_cnt, n_writes;
    bit seen_low;
    logic [31:0] done_addr_seen, ea;
    logic [15:0] ed;

    always @(negedge clk) if (!rst) begin
        if (spi_sclk) hi_run++;
        else begin
            if (hi_run > 0 && hi_run != HALF) bad_high++;
            hi_run = 0;
        end
        if (spi_cs_n && spi_sclk) bad_idle++;
        if (spi_cs_n) cs_hi_run++;
        else begin
            if (seen_low && cs_hi_run > 0 && cs_hi_run < min_gap) min_gap = cs_hi_run;
            seen_low = 1'b1;
            cs_hi_run = 0;
        end
        if (mem_we) begin
            n_writes++;
            if (exp_addr.size() == 0) chk(1'b0, "R8", "unexpected write", mem_addr, 0);
            else begin
                ea = exp_addr.pop_front();
                ed = exp_data.pop_front();
                chk(mem_addr == ea && mem_wdata == ed, "R8", "write addr/data",
                    {mem_addr, mem_wdata}, {ea, ed});
            end
        end
        if (load_done) begin
            done_cnt++;
            done_addr_seen = load_addr;
        end
    end

    function automatic logic [7:0] hdr_byte(input int i, input int ab);
        return (i - 1 - ab >= 0) ? ee_mem[i - 1 - ab] : 8'h00;
    endfunction

    task automatic run_case(input bit wide);
        int ab, skip, size, pulses, base, c;
        logic [7:0] b2, b3, b4;
        string rq;
        rst = 1'b1;
        dev_wide = wide;
        repeat (4) @(posedge clk);
        win = 0; bad_mosi = 0; cs_falls = 0; hi_run = 0; bad_high = 0; bad_idle = 0;
        cs_hi_run = 0; min_gap = 1 << 30; seen_low = 1'b0; done_cnt = 0; n_writes = 0;
        for (int i = 0; i < 8; i++) rises[i] = 0;
        exp_addr.delete();
        exp_data.delete();
        ab = wide ? 2 : 1;
        b2 = hdr_byte(2, ab); b3 = hdr_byte(3, ab); b4 = hdr_byte(4, ab);
        pulses = 0; skip = 0; size = 0;
        if (b2 == 8'h5A) begin skip = 4; size = b3; end
        else if (b3 == 8'h5A) begin skip = 5; size = b4; end
        else pulses = 2;
        if (pulses == 0 && size == 0) pulses = 3;
        rq = (skip == 5) ? "R5" : "R4";
        if (pulses == 0) begin
            base = skip - 1 - ab;
            for (int j = 0; j < size * 8; j++) begin
                exp_addr.push_back(TB_BASE + 32'(2 * j));
                exp_data.push_back({ee_mem[base + 2*j + 1], ee_mem[base + 2*j]});
            end
        end
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R9", "cs_n in reset", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R1", "sclk in reset", spi_sclk, 0);
        chk({load_done, halted, mem_we} == 3'b000, "R10", "outputs in reset",
            {load_done, halted, mem_we}, 0);
        rst = 1'b0;
        c = 0;
        while (c < 60000 && done_cnt == 0 && !halted) begin
            @(negedge clk);
            c++;
        end
        chk(c < 60000, "R10", "finish before timeout", c, 60000);
        repeat (300) @(negedge clk);
        chk(bad_mosi == 0, "R2", "command/zero bytes", bad_mosi, 0);
        chk(rises[0] == 48, "R11", "first pass edges", rises[0], 48);
        chk(bad_high == 0, "R3", "sclk high width", bad_high, 0);
        chk(bad_idle == 0, "R1", "sclk while deselected", bad_idle, 0);
        chk(min_gap >= 2 * HALF, "R9", "cs high gap", min_gap, 2 * HALF);
        chk(spi_cs_n == 1'b1, "R9", "cs high at end", spi_cs_n, 1);
        if (pulses == 0) begin
            chk(rises[1] == 8 * (skip + size * 16), rq, "second pass edges",
                rises[1], 8 * (skip + size * 16));
            chk(n_writes == size * 8 && exp_addr.size() == 0, "R8", "write count",
                n_writes, size * 8);
            chk(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
            chk(done_addr_seen == TB_BASE, "R10", "done address", done_addr_seen, TB_BASE);
            chk(halted == 1'b0, "R10", "not halted", halted, 0);
            chk(cs_falls == 2, rq, "cs low intervals", cs_falls, 2);
        end else begin
            rq = (pulses == 2) ? "R6" : "R7";
            chk(cs_falls == 1 + pulses, rq, "cs low intervals", cs_falls, 1 + pulses);
            chk(halted == 1'b1, rq, "halted", halted, 1);
            chk(done_cnt == 0 && n_writes == 0, rq, "no done/write", done_cnt + n_writes, 0);
        end
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 64; i++) ee_mem[i] = 8'((i * 37 + seed) & 255);
    endtask

    initial begin
        #(20 * 190000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R4: one address byte, size 1
        fill(3);  ee_mem[0] = 8'h5A; ee_mem[1] = 8'h01; run_case(1'b0);
        // R5: two address bytes, size 3
        fill(11); ee_mem[0] = 8'h5A; ee_mem[1] = 8'h03; run_case(1'b1);
        // R4: size 2 with marker-like and all-ones image bytes
        fill(90); ee_mem[0] = 8'h5A; ee_mem[1] = 8'h02; ee_mem[2] = 8'h5A; ee_mem[3] = 8'hFF;
        run_case(1'b0);
        // R6: bad marker, one address byte
        fill(5);  ee_mem[0] = 8'hA5; ee_mem[1] = 8'h11; run_case(1'b0);
        // R6: bad marker, two address bytes
        fill(7);  ee_mem[0] = 8'h00; ee_mem[1] = 8'h5B; run_case(1'b1);
        // R7: zero size, one address byte
        fill(9);  ee_mem[0] = 8'h5A; ee_mem[1] = 8'h00; run_case(1'b0);
        // R7: zero size, two address bytes
        fill(13); ee_mem[0] = 8'h5A; ee_mem[1] = 8'h00; run_case(1'b1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule